// File: doc/BRIEF.md
# Four-Way Physically Tagged Cache Lookup

This block is the hit/miss search path of a 16 KB, four-way set-associative cache. The set is selected from the virtual address of an access. Each of the four ways keeps a 256-entry array of physical tags, and a valid bit for each entry. In the cycle of a request, the block reads all four tag arrays at the virtual set index. In the same cycle, a translation unit outside the block supplies the physical address. The stored tags are compared with that physical address on the next cycle, in parallel across the four ways, and the block reports a hit flag, a one-hot way vector and a cacheable flag.

Whether a search happens at all depends on two things: a global enable input, and a decoder that classifies the top three bits of the virtual address into regions. The user region and two kernel regions are searched. The uncached kernel region and the control region bypass the cache. A separate maintenance port writes one tag entry with a chosen valid value. This port is used both to fill an entry and to invalidate it.

Top module: `cache_tag_lookup`

## Requirements
- R1: After reset every valid bit is clear, so any lookup to any set reports resp_hit=0 and resp_way=0.
- R2: When cache_en is 0 in the request cycle, the response has resp_cacheable=0 and resp_hit=0, even if a matching valid tag is stored.
- R3: req_vaddr[31:29] picks the region. The values 0 to 3 (user), 4 and 6 are searched and cacheable. The values 5 and 7 give resp_cacheable=0 and resp_hit=0.
- R4: The set index is req_vaddr[11:4]. Changing req_vaddr[3:0] or req_vaddr[28:12] has no effect on the result. An entry filled at one set is not seen by a lookup at another set.
- R5: The compared tag is req_paddr[31:10], taken in the request cycle. A lookup hits when these bits equal the stored tag. It misses when any of them differs, including bit 10.
- R6: A way hits only if its tag matches and its valid bit is 1. Writing a way with fill_valid=0 makes later lookups to that entry miss.
- R7: All four ways are searched together. resp_way bit i is set when way i (selected by fill_way=i) holds the match. resp_way is zero whenever resp_hit is 0.
- R8: resp_valid is 1 exactly one cycle after a cycle with req_valid=1. While resp_valid is 0, resp_hit, resp_way and resp_cacheable are 0.
- R9: A fill and a lookup to the same set in the same cycle work as follows: the lookup sees the contents from before the fill, and the next lookup sees the filled entry.
- R10: A fill writes only the selected way and set. The other ways of that set keep their tags and valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Global cache enable, sampled with the request |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address of the access |
| req_paddr | input | 32 | Translated physical address, same cycle as the request |
| fill_en | input | 1 | Write one tag entry |
| fill_way | input | 2 | Way to write |
| fill_set | input | 8 | Set to write |
| fill_tag | input | 22 | Physical tag (address bits 31:10) to store |
| fill_valid | input | 1 | Valid bit to store (0 invalidates) |
| resp_valid | output | 1 | Response present, one cycle after the request |
| resp_hit | output | 1 | Some way matched with valid set |
| resp_way | output | 4 | One-hot matching way |
| resp_cacheable | output | 1 | Access was enabled and in a cached region |

## Verification
The hardest case to reach is a fill and a lookup hitting the same set in the same cycle. In this case the order of the tag read and the tag write decides what the lookup sees. The bench drives the maintenance port and the request in the same cycle and checks that the response still reflects the old miss. It then repeats the lookup alone and expects the new hit. Virtual-index/physical-tag separation is another case that needs care. The bench reaches it by pairing one physical address with several unrelated virtual upper bits, and one virtual address with a physical address that differs only in bit 10.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

  typedef enum logic [2:0] {
    RGN_USER = 3'd0,
    RGN_KCACHED = 3'd1,
    RGN_KUNCACHED = 3'd2,
    RGN_KMAPPED = 3'd3,
    RGN_CONTROL = 3'd4
  } region_e;

  function automatic region_e region_of(input logic [2:0] top_bits);
    case (top_bits)
      3'd4:    return RGN_KCACHED;
      3'd5:    return RGN_KUNCACHED;
      3'd6:    return RGN_KMAPPED;
      3'd7:    return RGN_CONTROL;
      default: return RGN_USER;
    endcase
  endfunction

  function automatic logic region_searched(input region_e rgn);
    return (rgn == RGN_USER) || (rgn == RGN_KCACHED) || (rgn == RGN_KMAPPED);
  endfunction

endpackage

// File: rtl/cache_region_dec.sv
module cache_region_dec
  import cache_tag_pkg::*;
(
  input  logic [2:0] va_top,
  input  logic       enable,
  output logic       searched
);
  region_e rgn;

  always_comb begin
    rgn      = region_of(va_top);
    searched = enable && region_searched(rgn);
  end
endmodule

// File: rtl/cache_tag_way.sv
module cache_tag_way #(
  parameter int SET_BITS = 8,
  parameter int TAG_W    = 22
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [SET_BITS-1:0] wr_set,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic                rd_en,
  input  logic [SET_BITS-1:0] rd_set,
  output logic [TAG_W-1:0]    rd_tag
);
  localparam int SETS = 1 << SET_BITS;

  logic [TAG_W-1:0] mem [SETS];

  // Read-first single-clock RAM: a read and a write to the same set in the
  // same cycle return the old tag.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_set] <= wr_tag;
    if (rd_en) rd_tag <= mem[rd_set];
  end
endmodule

// File: rtl/cache_hit_cmp.sv
module cache_hit_cmp #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 22
) (
  input  logic                        active,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tags,
  input  logic [WAYS-1:0]             way_valid,
  input  logic [TAG_W-1:0]            phys_tag,
  output logic [WAYS-1:0]             match,
  output logic                        hit,
  output logic [WAYS-1:0]             hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = active && way_valid[w] && (way_tags[w] == phys_tag);
  end

  always_comb begin
    hit     = |match;
    // Lowest-numbered way wins if several ways match.
    hit_way = match & (~match + 1'b1);
  end
endmodule

// File: rtl/cache_tag_lookup.sv
module cache_tag_lookup #(
  parameter int ADDR_W    = 32,
  parameter int SET_BITS  = 8,
  parameter int LINE_BITS = 4,
  parameter int TAG_LSB   = 10,
  parameter int WAYS      = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cache_en,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_vaddr,
  input  logic [ADDR_W-1:0]          req_paddr,
  input  logic                       fill_en,
  input  logic [$clog2(WAYS)-1:0]    fill_way,
  input  logic [SET_BITS-1:0]        fill_set,
  input  logic [ADDR_W-TAG_LSB-1:0]  fill_tag,
  input  logic                       fill_valid,
  output logic                       resp_valid,
  output logic                       resp_hit,
  output logic [WAYS-1:0]            resp_way,
  output logic                       resp_cacheable
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - TAG_LSB;
  localparam int WAY_W = $clog2(WAYS);

  logic [SET_BITS-1:0]           rd_set;
  logic                          searched;
  logic [WAYS-1:0][TAG_W-1:0]    rd_tags;
  logic [WAYS-1:0]               valid_bits [SETS];
  logic [WAYS-1:0]               valid_q;
  logic [TAG_W-1:0]              ptag_q;
  logic                          active_q;
  logic                          rsp_q;
  logic [WAYS-1:0]               match;

  assign rd_set = req_vaddr[LINE_BITS +: SET_BITS];

  cache_region_dec u_rgn (
    .va_top   (req_vaddr[ADDR_W-1 -: 3]),
    .enable   (cache_en),
    .searched (searched)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache_tag_way #(.SET_BITS(SET_BITS), .TAG_W(TAG_W)) u_way (
      .clk    (clk),
      .wr_en  (fill_en && (fill_way == WAY_W'(w))),
      .wr_set (fill_set),
      .wr_tag (fill_tag),
      .rd_en  (req_valid),
      .rd_set (rd_set),
      .rd_tag (rd_tags[w])
    );
  end

  // Valid bits live in flops so reset can clear them; sampled read-first.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) valid_bits[s] <= '0;
    end else if (fill_en) begin
      valid_bits[fill_set][fill_way] <= fill_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q    <= 1'b0;
      active_q <= 1'b0;
      valid_q  <= '0;
      ptag_q   <= '0;
    end else begin
      rsp_q    <= req_valid;
      active_q <= req_valid && searched;
      if (req_valid) begin
        valid_q <= valid_bits[rd_set];
        ptag_q  <= req_paddr[ADDR_W-1:TAG_LSB];
      end
    end
  end

  cache_hit_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
    .active    (active_q),
    .way_tags  (rd_tags),
    .way_valid (valid_q),
    .phys_tag  (ptag_q),
    .match     (match),
    .hit       (resp_hit),
    .hit_way   (resp_way)
  );

  assign resp_valid     = rsp_q;
  assign resp_cacheable = active_q;
endmodule

// File: rtl/cache_tag_lookup_chk.sv
module cache_tag_lookup_chk #(
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            cache_en,
  input logic            req_valid,
  input logic [2:0]      req_top,
  input logic            resp_valid,
  input logic            resp_hit,
  input logic [WAYS-1:0] resp_way,
  input logic            resp_cacheable,
  input logic [WAYS-1:0] match
);
  p_resp_follows_req_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  p_no_resp_without_req_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> (!resp_hit && resp_way == '0 && !resp_cacheable));
  p_disabled_no_hit_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cache_en) |=> (!resp_hit && !resp_cacheable));
  p_bypass_region_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_top == 3'd5 || req_top == 3'd7)) |=> (!resp_hit && !resp_cacheable));
  p_way_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(resp_way) && (resp_hit == (resp_way != '0)));
  p_hit_needs_cacheable_r6: assert property (@(posedge clk) disable iff (rst)
    resp_hit |-> resp_cacheable);
  p_single_match_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(match) <= 1);
endmodule

bind cache_tag_lookup cache_tag_lookup_chk #(.WAYS(WAYS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cache_en       (cache_en),
  .req_valid      (req_valid),
  .req_top        (req_vaddr[ADDR_W-1 -: 3]),
  .resp_valid     (resp_valid),
  .resp_hit       (resp_hit),
  .resp_way       (resp_way),
  .resp_cacheable (resp_cacheable),
  .match          (match)
);

// File: tb/cache_tag_lookup_tb.sv
module cache_tag_lookup_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cache_en;
  logic        req_valid;
  logic [31:0] req_vaddr, req_paddr;
  logic        fill_en;
  logic [1:0]  fill_way;
  logic [7:0]  fill_set;
  logic [21:0] fill_tag;
  logic        fill_valid;
  logic        resp_valid, resp_hit, resp_cacheable;
  logic [3:0]  resp_way;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cache_tag_lookup u_dut (
    .clk(clk), .rst(rst), .cache_en(cache_en), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_paddr(req_paddr), .fill_en(fill_en),
    .fill_way(fill_way), .fill_set(fill_set), .fill_tag(fill_tag),
    .fill_valid(fill_valid), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_way(resp_way), .resp_cacheable(resp_cacheable)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] va(input logic [2:0] top, input logic [7:0] set,
                                     input logic [16:0] mid, input logic [3:0] low);
    return {top, mid, set, low};
  endfunction

  function automatic logic [31:0] pa(input logic [21:0] tag);
    return {tag, 10'h155};
  endfunction

  task automatic fill(input logic [1:0] w, input logic [7:0] s, input logic [21:0] t,
                      input logic v);
    @(negedge clk);
    fill_en = 1'b1; fill_way = w; fill_set = s; fill_tag = t; fill_valid = v;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // Drive a request; at the following negedge the response is on the ports.
  task automatic lookup(input logic [31:0] v, input logic [31:0] p);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = v; req_paddr = p;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_resp(input string req, input logic hit, input logic [3:0] way,
                             input logic cacheable);
    chk({req, " resp_valid"}, 32'(resp_valid), 32'd1);
    chk({req, " resp_hit"}, 32'(resp_hit), 32'(hit));
    chk({req, " resp_way"}, 32'(resp_way), 32'(way));
    chk({req, " resp_cacheable"}, 32'(resp_cacheable), 32'(cacheable));
  endtask

  task automatic t_reset;
    chk("R8 idle resp_valid", 32'(resp_valid), 32'd0);
    chk("R8 idle resp_hit", 32'(resp_hit), 32'd0);
    lookup(va(3'd0, 8'd0, 17'h0, 4'h0), pa(22'h0));
    expect_resp("R1 set0 after reset", 1'b0, 4'b0000, 1'b1);
    lookup(va(3'd4, 8'd200, 17'h0, 4'h0), pa(22'h12345));
    expect_resp("R1 set200 after reset", 1'b0, 4'b0000, 1'b1);
    @(negedge clk);
    chk("R8 resp drops", 32'(resp_valid), 32'd0);
    chk("R8 quiet way", 32'(resp_way), 32'd0);
  endtask

  task automatic t_ways;
    for (int w = 0; w < 4; w++) fill(2'(w), 8'd5, 22'h100 + 22'(w), 1'b1);
    for (int w = 0; w < 4; w++) begin
      lookup(va(3'd0, 8'd5, 17'h0, 4'h0), pa(22'h100 + 22'(w)));
      expect_resp("R7 way select", 1'b1, 4'(1 << w), 1'b1);
    end
    lookup(va(3'd0, 8'd5, 17'h0, 4'h0), pa(22'h104));
    expect_resp("R7 no way matches", 1'b0, 4'b0000, 1'b1);
  endtask

  task automatic t_region;
    fill(2'd2, 8'd9, 22'h2AAAA, 1'b1);
    for (int r = 0; r < 8; r++) begin
      logic ok;
      ok = !(r == 5 || r == 7);
      lookup(va(3'(r), 8'd9, 17'h0, 4'h0), pa(22'h2AAAA));
      expect_resp("R3 region", ok, ok ? 4'b0100 : 4'b0000, ok);
    end
  endtask

  task automatic t_enable;
    cache_en = 1'b0;
    lookup(va(3'd0, 8'd9, 17'h0, 4'h0), pa(22'h2AAAA));
    expect_resp("R2 disabled", 1'b0, 4'b0000, 1'b0);
    cache_en = 1'b1;
    lookup(va(3'd0, 8'd9, 17'h0, 4'h0), pa(22'h2AAAA));
    expect_resp("R2 re-enabled", 1'b1, 4'b0100, 1'b1);
  endtask

  task automatic t_index;
    lookup(va(3'd0, 8'd10, 17'h0, 4'h0), pa(22'h2AAAA));
    expect_resp("R4 other set", 1'b0, 4'b0000, 1'b1);
    lookup(va(3'd1, 8'd9, 17'h1ABCD, 4'hF), pa(22'h2AAAA));
    expect_resp("R4 ignored va bits", 1'b1, 4'b0100, 1'b1);
  endtask

  task automatic t_ptag;
    lookup(va(3'd0, 8'd9, 17'h0, 4'h0), pa(22'h2AAAA ^ 22'h1));
    expect_resp("R5 pa bit10 differs", 1'b0, 4'b0000, 1'b1);
    lookup(va(3'd6, 8'd9, 17'h0F0F0, 4'h3), {22'h2AAAA, 10'h3FF});
    expect_resp("R5 pa low bits ignored", 1'b1, 4'b0100, 1'b1);
  endtask

  task automatic t_inval;
    fill(2'd1, 8'd5, 22'h101, 1'b0);
    lookup(va(3'd0, 8'd5, 17'h0, 4'h0), pa(22'h101));
    expect_resp("R6 invalidated way", 1'b0, 4'b0000, 1'b1);
    lookup(va(3'd0, 8'd5, 17'h0, 4'h0), pa(22'h100));
    expect_resp("R10 way0 kept", 1'b1, 4'b0001, 1'b1);
    lookup(va(3'd0, 8'd5, 17'h0, 4'h0), pa(22'h103));
    expect_resp("R10 way3 kept", 1'b1, 4'b1000, 1'b1);
  endtask

  task automatic t_collide;
    @(negedge clk);
    fill_en = 1'b1; fill_way = 2'd3; fill_set = 8'd77; fill_tag = 22'h33333; fill_valid = 1'b1;
    req_valid = 1'b1; req_vaddr = va(3'd0, 8'd77, 17'h0, 4'h0); req_paddr = pa(22'h33333);
    @(negedge clk);
    fill_en = 1'b0; req_valid = 1'b0;
    expect_resp("R9 same-cycle sees old", 1'b0, 4'b0000, 1'b1);
    lookup(va(3'd0, 8'd77, 17'h0, 4'h0), pa(22'h33333));
    expect_resp("R9 next sees new", 1'b1, 4'b1000, 1'b1);
  endtask

  initial begin
    rst = 1'b1; cache_en = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_paddr = '0;
    fill_en = 1'b0; fill_way = '0; fill_set = '0; fill_tag = '0; fill_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ways();
    t_region();
    t_enable();
    t_index();
    t_ptag();
    t_inval();
    t_collide();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule